// File: doc/BRIEF.md
# Serial DAC Frame Transmitter

This block sits on the host side of a dual-channel serial converter link and acts as the bus master. A client presents a request made of a 4-bit command, a 4-bit channel address, a 16-bit sample and a frame-length select. The request is taken on a valid/ready handshake. The block then drives a frame-enable line (active low), a serial clock and a serial data line. The frame-enable line is the chip select, and its rising edge is also what loads the word into the converter.

A frame carries 24 bits, or 32 bits when the long format is selected. The long format puts eight zero pad bits in front of the 24 payload bits. All bits go out MSB first. Data changes only on the falling serial clock edge, so the converter samples stable data on every rising edge.

Each minimum interval is a parameter in picoseconds and is converted to system clock cycles at elaboration. These intervals are the clock high and low time, the data setup and hold, the enable setup and hold around the clock, and the enable high time. A run-time divider input sets the serial clock half period. A value smaller than the safe minimum is raised to that minimum. The divider value is latched with each request. A one-cycle done pulse marks the cycle in which the frame is loaded.

Top module: `dac_frame_tx`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, cs_o is 1, sclk_o is 0, sdo_o is 0, req_ready_o is 1 and done_o is 0.
- R2: A request is captured only on a rising clock edge where req_valid_i and req_ready_o are both 1. Asserting req_valid_i while req_ready_o is 0 produces no frame.
- R3: req_ready_o is 0 from the capture edge until cs_o has been high for at least GAP_CYC cycles (3 at the defaults). While cs_o is low, req_ready_o is 0.
- R4: With req_long_i = 0, exactly 24 rising sclk_o edges occur while cs_o is low. On these edges sdo_o carries cmd[3:0], then addr[3:0], then data[15:0], each MSB first.
- R5: With req_long_i = 1, exactly 32 rising edges occur. The first 8 carry 0, and the remaining 24 carry the same sequence as in R4.
- R6: sdo_o never changes while sclk_o is high. It changes only in the cycle in which sclk_o falls, or when a frame starts.
- R7: The sclk_o high and low phases each last H cycles, where H = max(div_i, MIN_HALF_CYC) and MIN_HALF_CYC is 3 at the defaults. div_i is sampled at capture, and later changes to it do not affect the frame in progress.
- R8: sclk_o is low whenever cs_o is high. At least SETUP_CYC cycles (2) pass between cs_o falling and the first rising sclk_o edge. At least HOLD_CYC cycles (2) pass between the last rising edge and cs_o rising.
- R9: done_o is high for exactly one cycle per frame, and that cycle is the first cycle in which cs_o is high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Ready to accept a request |
| req_cmd_i | input | CMD_W | Command nibble |
| req_addr_i | input | ADDR_W | Channel address nibble |
| req_data_i | input | DATA_W | Sample word |
| req_long_i | input | 1 | 1 selects the padded 32-bit frame |
| div_i | input | DIV_W | Requested serial clock half period, in system cycles |
| cs_o | output | 1 | Frame enable and load strobe, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| sdo_o | output | 1 | Serial data |
| done_o | output | 1 | One-cycle pulse when the frame is loaded |

## Verification
The bench goes after these corner cases:

- **Divider below the floor.** A divider value under the minimum must be clamped. A design that passes it through would produce a half period of one cycle, and the measured high time would fall short.
- **Divider changed mid-frame.** A change of the divider during a frame must be ignored. A design that reads the live input would stretch or shrink the later phases of that frame.
- **Request while busy.** A request presented while busy must not start a frame. A design that captures it would emit an extra frame that no request accounts for.
- **Frame length and pad bits.** Both frame lengths are checked bit by bit. A design that counted wrongly, or drove the pad bits high, would shift the payload or corrupt the leading bits.
- **Enable timing and done pulse.** The enable gap and the done pulse are timed against the enable edge. This catches a done pulse one cycle early or late, and a ready signal that rises before the minimum high time has elapsed.

// File: rtl/dac_frame_pkg.sv
package dac_frame_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_HOLD,
    ST_GAP
  } frame_state_e;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dac_frame_timer.sv
module dac_frame_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  // last cycle of a phase that lasts len_i cycles
  assign last_o = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, len_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (!last_o) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/dac_frame_shift.sv
module dac_frame_shift #(
  parameter int CMD_W  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int PAD_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              long_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              bit_o,
  output logic              last_o
);

  localparam int BODY_LEN = CMD_W + ADDR_W + DATA_W;
  localparam int LONG_LEN = BODY_LEN + PAD_W;
  localparam int BCNT_W   = $clog2(LONG_LEN + 1);

  logic [LONG_LEN-1:0] sh_q;
  logic [LONG_LEN-1:0] frame_long, frame_short;
  logic [BCNT_W-1:0]   bits_q;
  logic [BODY_LEN-1:0] body;

  assign body = {cmd_i, addr_i, data_i};

  generate
    if (PAD_W > 0) begin : g_pad
      assign frame_long  = {{PAD_W{1'b0}}, body};
      assign frame_short = {body, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign frame_long  = body;
      assign frame_short = body;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bits_q <= '0;
    end else if (load_i) begin
      sh_q   <= long_i ? frame_long : frame_short;
      bits_q <= long_i ? BCNT_W'(LONG_LEN) : BCNT_W'(BODY_LEN);
    end else if (shift_i) begin
      sh_q   <= {sh_q[LONG_LEN-2:0], 1'b0};
      bits_q <= bits_q - BCNT_W'(1);
    end
  end

  assign bit_o  = sh_q[LONG_LEN-1];
  assign last_o = (bits_q == BCNT_W'(1));

endmodule

// File: rtl/dac_frame_ctrl.sv
module dac_frame_ctrl
  import dac_frame_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int MIN_HALF  = 3,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 2,
  parameter int GAP_CYC   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             tmr_last_i,
  input  logic             last_bit_i,
  output logic [DIV_W-1:0] tmr_len_o,
  output logic             tmr_restart_o,
  output logic             load_o,
  output logic             shift_o,
  output logic             ready_o,
  output logic             cs_o,
  output logic             sclk_o,
  output logic             done_o
);

  localparam logic [DIV_W-1:0] MIN_V   = DIV_W'(MIN_HALF);
  localparam logic [DIV_W-1:0] SETUP_V = DIV_W'(SETUP_CYC);
  localparam logic [DIV_W-1:0] HOLD_V  = DIV_W'(HOLD_CYC);
  localparam logic [DIV_W-1:0] GAP_V   = DIV_W'(GAP_CYC);

  frame_state_e     st_q, st_d;
  logic [DIV_W-1:0] half_q;
  logic             done_q;

  always_comb begin
    st_d    = st_q;
    shift_o = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (req_valid_i) st_d = ST_SETUP;
      ST_SETUP: if (tmr_last_i) st_d = ST_HIGH;
      ST_HIGH: begin
        if (tmr_last_i) begin
          if (last_bit_i) begin
            st_d = ST_HOLD;
          end else begin
            st_d    = ST_LOW;
            shift_o = 1'b1;   // next bit on the falling edge
          end
        end
      end
      ST_LOW:   if (tmr_last_i) st_d = ST_HIGH;
      ST_HOLD:  if (tmr_last_i) st_d = ST_GAP;
      ST_GAP:   if (tmr_last_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_q)
      ST_SETUP:       tmr_len_o = SETUP_V;
      ST_HIGH, ST_LOW: tmr_len_o = half_q;
      ST_HOLD:        tmr_len_o = HOLD_V;
      ST_GAP:         tmr_len_o = GAP_V;
      default:        tmr_len_o = DIV_W'(1);
    endcase
  end

  assign load_o        = (st_q == ST_IDLE) && req_valid_i;
  assign tmr_restart_o = (st_d != st_q);
  assign ready_o       = (st_q == ST_IDLE);
  assign cs_o          = (st_q == ST_IDLE) || (st_q == ST_GAP);
  assign sclk_o        = (st_q == ST_HIGH);
  assign done_o        = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      half_q <= MIN_V;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_HOLD) && tmr_last_i;
      if (load_o) half_q <= (div_i < MIN_V) ? MIN_V : div_i;
    end
  end

endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx
  import dac_frame_pkg::*;
#(
  parameter int CLK_PS       = 4000,
  parameter int DIV_W        = 8,
  parameter int CMD_W        = 4,
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 16,
  parameter int PAD_W        = 8,
  parameter int T_DAT_SU_PS  = 4000,
  parameter int T_DAT_HD_PS  = 4000,
  parameter int T_SCK_HL_PS  = 9000,
  parameter int T_SCK_PER_PS = 20000,
  parameter int T_CS_SU_PS   = 7000,
  parameter int T_CS_HD_PS   = 7000,
  parameter int T_CS_HI_PS   = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [CMD_W-1:0]  req_cmd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic              req_long_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              cs_o,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              done_o
);

  localparam int MIN_HALF_CYC = imax(
      imax(cdiv(T_SCK_HL_PS, CLK_PS), cdiv(T_SCK_PER_PS, 2 * CLK_PS)),
      imax(cdiv(T_DAT_SU_PS, CLK_PS), cdiv(T_DAT_HD_PS, CLK_PS)));
  localparam int SETUP_CYC = imax(cdiv(T_CS_SU_PS, CLK_PS), 1);
  localparam int HOLD_CYC  = imax(cdiv(T_CS_HD_PS, CLK_PS), 1);
  localparam int GAP_CYC   = imax(cdiv(T_CS_HI_PS, CLK_PS), 1);

  logic [DIV_W-1:0] tmr_len;
  logic             tmr_restart, tmr_last;
  logic             load, shift, sh_bit, sh_last;
  logic             cs_int;

  dac_frame_timer #(.CNT_W(DIV_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(tmr_restart),
    .len_i    (tmr_len),
    .last_o   (tmr_last)
  );

  dac_frame_shift #(
    .CMD_W (CMD_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .PAD_W (PAD_W)
  ) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .long_i (req_long_i),
    .cmd_i  (req_cmd_i),
    .addr_i (req_addr_i),
    .data_i (req_data_i),
    .shift_i(shift),
    .bit_o  (sh_bit),
    .last_o (sh_last)
  );

  dac_frame_ctrl #(
    .DIV_W    (DIV_W),
    .MIN_HALF (MIN_HALF_CYC),
    .SETUP_CYC(SETUP_CYC),
    .HOLD_CYC (HOLD_CYC),
    .GAP_CYC  (GAP_CYC)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .div_i        (div_i),
    .tmr_last_i   (tmr_last),
    .last_bit_i   (sh_last),
    .tmr_len_o    (tmr_len),
    .tmr_restart_o(tmr_restart),
    .load_o       (load),
    .shift_o      (shift),
    .ready_o      (req_ready_o),
    .cs_o         (cs_int),
    .sclk_o       (sclk_o),
    .done_o       (done_o)
  );

  assign cs_o  = cs_int;
  assign sdo_o = cs_int ? 1'b0 : sh_bit;

endmodule

// File: rtl/dac_frame_chk.sv
module dac_frame_chk #(
  parameter int MIN_HALF  = 3,
  parameter int SETUP_CYC = 2,
  parameter int GAP_CYC   = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_o,
  input logic sclk_o,
  input logic sdo_o,
  input logic done_o,
  input logic req_ready_o
);

  logic [7:0] hi_run_q, cs_lo_q, cs_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run_q <= '0;
      cs_lo_q  <= '0;
      cs_hi_q  <= 8'hff;
    end else begin
      hi_run_q <= !sclk_o ? 8'd0 : (hi_run_q == 8'hff ? hi_run_q : hi_run_q + 8'd1);
      cs_lo_q  <= cs_o ? 8'd0 : (cs_lo_q == 8'hff ? cs_lo_q : cs_lo_q + 8'd1);
      cs_hi_q  <= !cs_o ? 8'd0 : (cs_hi_q == 8'hff ? cs_hi_q : cs_hi_q + 8'd1);
    end
  end

  // R1
  idle_sdo_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |-> !sdo_o);
  // R3
  ready_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_o |-> !req_ready_o);
  // R3
  cs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> cs_hi_q >= 8'(GAP_CYC));
  // R6
  sdo_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sdo_o));
  // R7
  half_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> hi_run_q >= 8'(MIN_HALF));
  // R8
  idle_sclk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |-> !sclk_o);
  // R8
  cs_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> cs_lo_q >= 8'(SETUP_CYC));
  // R9
  done_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(cs_o));
  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

bind dac_frame_tx dac_frame_chk #(
  .MIN_HALF (MIN_HALF_CYC),
  .SETUP_CYC(SETUP_CYC),
  .GAP_CYC  (GAP_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_o       (cs_o),
  .sclk_o     (sclk_o),
  .sdo_o      (sdo_o),
  .done_o     (done_o),
  .req_ready_o(req_ready_o)
);

// File: tb/sim_dac_frame_tx.sv
`timescale 1ns/1ps
module sim_dac_frame_tx;

  localparam int MIN_H = 3;
  localparam int SU    = 2;
  localparam int HD    = 2;
  localparam int GAP   = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        ready;
  logic [3:0]  cmd = '0;
  logic [3:0]  addr = '0;
  logic [15:0] data = '0;
  logic        lng = 1'b0;
  logic [7:0]  div = 8'd3;
  logic        cs, sclk, sdo, done;

  int checks = 0;
  int errors = 0;
  int frames_sent = 0;
  int frames_seen = 0;

  int          q_len[$];
  logic [31:0] q_bits[$];
  int          q_half[$];

  always #2 clk = ~clk;

  dac_frame_tx u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .req_valid_i(valid),
    .req_ready_o(ready),
    .req_cmd_i  (cmd),
    .req_addr_i (addr),
    .req_data_i (data),
    .req_long_i (lng),
    .div_i      (div),
    .cs_o       (cs),
    .sclk_o     (sclk),
    .sdo_o      (sdo),
    .done_o     (done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: waits for ready, presents one request, queues the expected frame
  task automatic send(input logic [3:0] c, input logic [3:0] a, input logic [15:0] d,
                      input logic l, input logic [7:0] dv);
    @(negedge clk);
    while (!ready) @(negedge clk);
    cmd = c; addr = a; data = d; lng = l; div = dv; valid = 1'b1;
    q_len.push_back(l ? 32 : 24);
    q_bits.push_back({8'h00, c, a, d});
    q_half.push_back((dv < MIN_H) ? MIN_H : int'(dv));
    frames_sent++;
    @(negedge clk);
    valid = 1'b0;
  endtask

  // monitor
  logic        p_cs = 1'b1, p_sclk = 1'b0, p_sdo = 1'b0, p_ready = 1'b1;
  int          cyc = 0, t_fall = 0, t_rise = 0, t_sfall = 0, t_csrise = -100;
  int          nbits = 0, cur_half = 0;
  logic [31:0] got = '0;
  bit          in_frame = 1'b0, seen_rise = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (cs && sclk) check(1'b0, "R8 sclk high while idle", 1, 0);
      if (cs && sdo) check(1'b0, "R1 sdo high while idle", 1, 0);
      if (!cs && ready) check(1'b0, "R3 ready while busy", 1, 0);
      if (sclk && p_sclk && (sdo != p_sdo)) check(1'b0, "R6 sdo moved while sclk high", sdo, p_sdo);
      if (done && !(cs && !p_cs)) check(1'b0, "R9 stray done", 1, 0);
      if (ready && !p_ready && t_csrise >= 0)
        check(cyc - t_csrise >= GAP, "R3 ready before gap", cyc - t_csrise, GAP);
      if (!cs && p_cs) begin
        check(cyc - t_csrise >= GAP, "R3 cs high gap", cyc - t_csrise, GAP);
        if (q_half.size() == 0) begin
          check(1'b0, "R2 unexpected frame", 1, 0);
          cur_half = MIN_H;
        end else cur_half = q_half[0];
        in_frame = 1'b1; seen_rise = 1'b0; nbits = 0; got = '0; t_fall = cyc;
      end
      if (in_frame && sclk && !p_sclk) begin
        if (!seen_rise) check(cyc - t_fall >= SU, "R8 cs to first sclk", cyc - t_fall, SU);
        else check(cyc - t_sfall == cur_half, "R7 low phase", cyc - t_sfall, cur_half);
        seen_rise = 1'b1; t_rise = cyc;
        got = {got[30:0], sdo};
        nbits++;
      end
      if (in_frame && !sclk && p_sclk) begin
        check(cyc - t_rise == cur_half, "R7 high phase", cyc - t_rise, cur_half);
        t_sfall = cyc;
      end
      if (cs && !p_cs) begin
        in_frame = 1'b0; t_csrise = cyc; frames_seen++;
        check(done == 1'b1, "R9 done at cs rise", done, 1);
        check(cyc - t_rise >= HD, "R8 last sclk to cs", cyc - t_rise, HD);
        if (q_len.size() != 0) begin
          check(nbits == q_len[0], (q_len[0] == 32) ? "R5 length" : "R4 length", nbits, q_len[0]);
          check(got == q_bits[0], (q_len[0] == 32) ? "R5 bits" : "R4 bits", got, q_bits[0]);
          void'(q_len.pop_front()); void'(q_bits.pop_front()); void'(q_half.pop_front());
        end
      end
      p_cs = cs; p_sclk = sclk; p_sdo = sdo; p_ready = ready;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state during and right after reset
    check(cs == 1'b1 && sclk == 1'b0 && sdo == 1'b0 && ready == 1'b1 && done == 1'b0,
          "R1 reset outputs", {cs, sclk, sdo, ready, done}, 5'b10010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(cs == 1'b1 && sclk == 1'b0 && ready == 1'b1, "R1 idle outputs",
          {cs, sclk, ready}, 3'b101);

    // R4: short frame
    send(4'h3, 4'h0, 16'hA5C3, 1'b0, 8'd3);
    // R5: long frame with pad
    send(4'h2, 4'h1, 16'hFFFF, 1'b1, 8'd4);
    // R7: divider below the floor is clamped
    send(4'hF, 4'hF, 16'h0001, 1'b0, 8'd1);
    // R7: divider latched, mid-frame change ignored
    send(4'h1, 4'h0, 16'h8000, 1'b1, 8'd6);
    div = 8'd2;
    // R2: request while busy is dropped
    repeat (4) @(negedge clk);
    check(ready == 1'b0, "R2 busy before stray request", ready, 0);
    cmd = 4'h9; addr = 4'h9; data = 16'h1234; valid = 1'b1;
    repeat (2) @(negedge clk);
    valid = 1'b0;
    // R3: back to back requests
    send(4'h0, 4'h1, 16'h5A5A, 1'b0, 8'd3);
    send(4'hC, 4'h3, 16'h0000, 1'b1, 8'd3);
    send(4'h4, 4'h2, 16'h7FFE, 1'b0, 8'd5);

    @(negedge clk);
    while (!ready || q_len.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    // R2: no extra frame appeared
    check(frames_seen == frames_sent, "R2 frame count", frames_seen, frames_sent);
    check(cs == 1'b1 && sclk == 1'b0 && done == 1'b0, "R1 idle after traffic",
          {cs, sclk, done}, 3'b100);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule